// File: doc/BRIEF.md
# System Global Power State Sequencer

This block sequences a platform through its global power states: mechanical-off, soft-off, four sleeping depths (S1 to S4) and the working state S0. Software drives it through a small register port. One register switches the platform between legacy mode and OS-directed mode. A second register carries a sleep-depth code and a trigger bit, and a write to it asks for a sleep or soft-off transition.

Hardware events also move the state. A power-good input lifts the platform out of mechanical-off. A power-button press boots the platform from soft-off or from the deepest sleep. Wake events resume from any sleep depth. An override button forces soft-off. A power-fail input drops to mechanical-off from any state. From the current state the block produces a one-hot state vector and four enables: CPU context retention, cache retention, memory self-refresh and the main rail.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset the state is mechanical-off, the mode flag `sci_en` is 0 and all four enables are 0.
- R2: In mechanical-off, `pwr_good` high moves the state to soft-off on the next clock edge. In any other state `pwr_good` has no effect.
- R3: `pwrbtn_press` in soft-off or S4 moves the state to S0 on the next edge. In G3, S0, S1, S2 and S3 it has no effect.
- R4: A write to address 0 with bit 0 set and bit 1 clear sets `sci_en`. Bit 1 set with bit 0 clear clears it. Both set, or both clear, leave it unchanged. While the state is soft-off or mechanical-off, `sci_en` is forced to 0 on the next edge.
- R5: A write to address 1 has the sleep code in bits [2:0] and the trigger in bit 3. In S0, with `sci_en`=1 and the trigger set, codes 1 to 4 move the state to S1 to S4 on the next edge.
- R6: Under the same conditions, code 5 moves the state from S0 to soft-off.
- R7: A sleep write has no effect if the trigger is clear, if the code is 0, 6 or 7, or if `sci_en` is 0. The trigger is never stored, so it cannot fire later.
- R8: Any bit of `wake_evt` in S1 to S4 returns the state to S0 on the next edge. In S0, soft-off and mechanical-off it has no effect.
- R9: `pwrbtn_ovr` in any state except mechanical-off moves the state to soft-off. It takes priority over wake events, button presses and sleep writes.
- R10: `pwr_fail` moves any state to mechanical-off on the next edge and takes priority over every other input.
- R11: Enables `{cpu_ctx_ret, cache_ret, mem_sref, main_rail_en}` by state are: S0 and S1 = 1101, S2 = 0001, S3 = 0010, S4, soft-off and mechanical-off = 0000.
- R12: `state_oh` always has exactly one bit set. Bit 0 is S0, bits 1 to 4 are S1 to S4, bit 5 is soft-off and bit 6 is mechanical-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 mode control, 1 sleep command) |
| reg_wdata | input | DATA_W | Register write data |
| wake_evt | input | N_WAKE | Wake event lines, any one wakes |
| pwrbtn_press | input | 1 | Power button press |
| pwrbtn_ovr | input | 1 | Power button override, forces soft-off |
| pwr_fail | input | 1 | Power failure |
| pwr_good | input | 1 | Supply good |
| state_oh | output | 7 | One-hot global state |
| sci_en | output | 1 | 1 = OS-directed mode, 0 = legacy mode |
| cpu_ctx_ret | output | 1 | Retain CPU context |
| cache_ret | output | 1 | Retain cache contents |
| mem_sref | output | 1 | Memory in self-refresh |
| main_rail_en | output | 1 | Main supply rail on |

## Verification
The bench drives each sleep code in S0 and checks for the exact target state and its enables. A design with an off-by-one code decode would land in the wrong depth or in soft-off. Reserved codes, a clear trigger and legacy mode must each leave S0 unchanged; a design that decodes loosely would drop into sleep. Conflicts are also covered: override together with wake, and power-fail together with power-good. A design with the priority reversed would wake, or would reach soft-off during a fail. The bench also checks that mode is lost on soft-off and that the button acts only from soft-off and S4. A design that skips these would keep stale OS-directed mode across a boot, or would resume from S1 to S3 on a press.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int NUM_STATES = 7;
    localparam int CODE_W     = 3;

    // Encoding value equals the one-hot bit position of the state.
    typedef enum logic [CODE_W-1:0] {
        ST_S0 = 3'd0,
        ST_S1 = 3'd1,
        ST_S2 = 3'd2,
        ST_S3 = 3'd3,
        ST_S4 = 3'd4,
        ST_S5 = 3'd5,
        ST_G3 = 3'd6
    } gstate_e;

    typedef struct packed {
        logic cpu_ret;
        logic cache_ret;
        logic mem_sref;
        logic rail_en;
    } rails_t;

    typedef struct packed {
        logic    valid;
        gstate_e target;
    } sleep_cmd_t;

endpackage

// File: rtl/pss_regs.sv
module pss_regs
    import pss_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              in_off,
    output logic              sci_en,
    output sleep_cmd_t        cmd
);

    localparam logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] SLEEP_ADDR = ADDR_W'(1);
    localparam int ON_BIT   = 0;
    localparam int OFF_BIT  = 1;
    localparam int CODE_LSB = 0;
    localparam int TRIG_BIT = CODE_LSB + CODE_W;

    typedef struct packed {
        logic sci;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [CODE_W-1:0] code;
    logic mode_wr, sleep_wr;

    always_comb begin
        mode_wr  = wr && (addr == MODE_ADDR);
        sleep_wr = wr && (addr == SLEEP_ADDR);
        code     = wdata[CODE_LSB +: CODE_W];

        regs_d = regs_q;
        if (in_off) begin
            regs_d.sci = 1'b0;
        end else if (mode_wr) begin
            if (wdata[ON_BIT] && !wdata[OFF_BIT]) begin
                regs_d.sci = 1'b1;
            end else if (wdata[OFF_BIT] && !wdata[ON_BIT]) begin
                regs_d.sci = 1'b0;
            end
        end

        // Trigger bit acts only in the cycle it is written.
        cmd.valid  = sleep_wr && wdata[TRIG_BIT] && regs_q.sci
                     && (code >= 3'd1) && (code <= 3'd5);
        cmd.target = gstate_e'(code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sci_en = regs_q.sci;

endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
    import pss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sleep_cmd_t cmd,
    input  logic       wake,
    input  logic       press,
    input  logic       ovr,
    input  logic       fail,
    input  logic       good,
    output gstate_e    state
);

    typedef struct packed {
        gstate_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (fail) begin
            fsm_d.st = ST_G3;
        end else begin
            unique case (fsm_q.st)
                ST_G3: begin
                    if (good) fsm_d.st = ST_S5;
                end
                ST_S5: begin
                    if (!ovr && press) fsm_d.st = ST_S0;
                end
                ST_S0: begin
                    if (ovr)            fsm_d.st = ST_S5;
                    else if (cmd.valid) fsm_d.st = cmd.target;
                end
                ST_S1, ST_S2, ST_S3: begin
                    if (ovr)       fsm_d.st = ST_S5;
                    else if (wake) fsm_d.st = ST_S0;
                end
                ST_S4: begin
                    if (ovr)                fsm_d.st = ST_S5;
                    else if (wake || press) fsm_d.st = ST_S0;
                end
                default: fsm_d.st = ST_G3;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st <= ST_G3;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;

endmodule

// File: rtl/pss_rails.sv
module pss_rails
    import pss_pkg::*;
(
    input  gstate_e                 state,
    output logic [NUM_STATES-1:0]   state_oh,
    output rails_t                  rails
);

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
        assign state_oh[i] = (CODE_W'(state) == CODE_W'(i));
    end

    always_comb begin
        rails = '0;
        unique case (state)
            ST_S0, ST_S1: rails = '{cpu_ret: 1'b1, cache_ret: 1'b1,
                                    mem_sref: 1'b0, rail_en: 1'b1};
            ST_S2:        rails = '{cpu_ret: 1'b0, cache_ret: 1'b0,
                                    mem_sref: 1'b0, rail_en: 1'b1};
            ST_S3:        rails = '{cpu_ret: 1'b0, cache_ret: 1'b0,
                                    mem_sref: 1'b1, rail_en: 1'b0};
            default:      rails = '0;
        endcase
    end

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pss_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 4,
    parameter int N_WAKE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic [N_WAKE-1:0]     wake_evt,
    input  logic                  pwrbtn_press,
    input  logic                  pwrbtn_ovr,
    input  logic                  pwr_fail,
    input  logic                  pwr_good,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  sci_en,
    output logic                  cpu_ctx_ret,
    output logic                  cache_ret,
    output logic                  mem_sref,
    output logic                  main_rail_en
);

    gstate_e    state;
    sleep_cmd_t cmd;
    rails_t     rails;
    logic       in_off;

    assign in_off = (state == ST_S5) || (state == ST_G3);

    pss_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .in_off (in_off),
        .sci_en (sci_en),
        .cmd    (cmd)
    );

    pss_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .wake  (|wake_evt),
        .press (pwrbtn_press),
        .ovr   (pwrbtn_ovr),
        .fail  (pwr_fail),
        .good  (pwr_good),
        .state (state)
    );

    pss_rails u_rails (
        .state    (state),
        .state_oh (state_oh),
        .rails    (rails)
    );

    assign cpu_ctx_ret  = rails.cpu_ret;
    assign cache_ret    = rails.cache_ret;
    assign mem_sref     = rails.mem_sref;
    assign main_rail_en = rails.rail_en;

endmodule

// File: rtl/pss_checks.sv
module pss_checks #(
    parameter int N_WAKE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_WAKE-1:0] wake_evt,
    input logic              pwrbtn_ovr,
    input logic              pwr_fail,
    input logic              pwr_good,
    input logic [6:0]        state_oh,
    input logic              sci_en,
    input logic              mem_sref,
    input logic              main_rail_en
);

    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    a_r10_fail_to_g3: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> state_oh[6]);

    a_r9_override: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_ovr && !pwr_fail && !state_oh[6]) |=> state_oh[5]);

    a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wake_evt) && !pwr_fail && !pwrbtn_ovr && (|state_oh[4:1])) |=> state_oh[0]);

    a_r7_legacy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[0] && !sci_en && !pwr_fail && !pwrbtn_ovr) |=> state_oh[0]);

    a_r4_off_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[5] || state_oh[6]) |=> !sci_en);

    a_r2_power_good: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[6] && pwr_good && !pwr_fail) |=> state_oh[5]);

    a_r11_rail_states: assert property (@(posedge clk) disable iff (!rst_n)
        main_rail_en |-> (|state_oh[2:0]));

    a_r11_sref_state: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sref |-> state_oh[3]);

endmodule

bind pwr_state_seq pss_checks #(.N_WAKE(N_WAKE)) u_pss_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_evt     (wake_evt),
    .pwrbtn_ovr   (pwrbtn_ovr),
    .pwr_fail     (pwr_fail),
    .pwr_good     (pwr_good),
    .state_oh     (state_oh),
    .sci_en       (sci_en),
    .mem_sref     (mem_sref),
    .main_rail_en (main_rail_en)
);

// File: tb/pwr_state_seq_test.sv
module pwr_state_seq_test;

    localparam int S0 = 0, S1 = 1, S2 = 2, S3 = 3, S4 = 4, S5 = 5, G3 = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] wake_evt = '0;
    logic       pwrbtn_press = 1'b0, pwrbtn_ovr = 1'b0;
    logic       pwr_fail = 1'b0, pwr_good = 1'b0;
    logic [6:0] state_oh;
    logic       sci_en, cpu_ctx_ret, cache_ret, mem_sref, main_rail_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_state_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wake_evt(wake_evt), .pwrbtn_press(pwrbtn_press),
        .pwrbtn_ovr(pwrbtn_ovr), .pwr_fail(pwr_fail), .pwr_good(pwr_good),
        .state_oh(state_oh), .sci_en(sci_en), .cpu_ctx_ret(cpu_ctx_ret),
        .cache_ret(cache_ret), .mem_sref(mem_sref), .main_rail_en(main_rail_en)
    );

    function automatic logic [3:0] exp_rails(int s);
        case (s)
            S0, S1:  return 4'b1101;
            S2:      return 4'b0001;
            S3:      return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_state(string req, int s);
        chk(req, {1'b0, state_oh}, 8'(1 << s));
        chk({req, " R11"}, {4'b0, cpu_ctx_ret, cache_ret, mem_sref, main_rail_en},
            {4'b0, exp_rails(s)});
    endtask

    // Each stimulus is held for one rising edge; results are sampled at the following falling edge.
    task automatic wr_reg(logic [1:0] a, logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic wake_pulse(logic [3:0] v);
        @(negedge clk); wake_evt = v;
        @(negedge clk); wake_evt = '0;
    endtask

    task automatic boot_to_s0_acpi();
        pulse(pwrbtn_press);
        wr_reg(2'd0, 4'b0001);
    endtask

    task automatic t_reset();
        chk_state("R1 reset state", G3);
        chk("R1 reset mode", {7'b0, sci_en}, 8'd0);
    endtask

    task automatic t_power_up();
        wake_pulse(4'b0001);
        chk_state("R8 wake ignored in G3", G3);
        pulse(pwrbtn_press);
        chk_state("R3 press ignored in G3", G3);
        pulse(pwrbtn_ovr);
        chk_state("R9 override ignored in G3", G3);
        pulse(pwr_good);
        chk_state("R2 power good to S5", S5);
        pulse(pwr_good);
        chk_state("R2 power good ignored in S5", S5);
        pulse(pwrbtn_press);
        chk_state("R3 press boots S5 to S0", S0);
    endtask

    task automatic t_mode();
        chk("R4 legacy after boot", {7'b0, sci_en}, 8'd0);
        wr_reg(2'd1, 4'b1011);
        chk_state("R7 sleep write ignored in legacy", S0);
        wr_reg(2'd0, 4'b0001);
        chk("R4 enable sets mode", {7'b0, sci_en}, 8'd1);
        wr_reg(2'd0, 4'b0011);
        chk("R4 both bits no change", {7'b0, sci_en}, 8'd1);
        wr_reg(2'd0, 4'b0010);
        chk("R4 disable clears mode", {7'b0, sci_en}, 8'd0);
        wr_reg(2'd0, 4'b0011);
        chk("R4 both bits no change low", {7'b0, sci_en}, 8'd0);
        wr_reg(2'd0, 4'b0001);
        pulse(pwrbtn_press);
        chk_state("R3 press ignored in S0", S0);
        wake_pulse(4'b0100);
        chk_state("R8 wake ignored in S0", S0);
    endtask

    task automatic t_sleep(int depth);
        wr_reg(2'd1, 4'(8 + depth));
        chk_state($sformatf("R5 sleep code %0d", depth), depth);
        if (depth != S4) begin
            pulse(pwrbtn_press);
            chk_state("R3 press ignored in S1-S3", depth);
        end
        pulse(pwr_good);
        chk_state("R2 power good ignored while sleeping", depth);
        if (depth == S4) begin
            pulse(pwrbtn_press);
            chk_state("R3 press wakes S4", S0);
        end else begin
            wake_pulse(4'(1 << (depth - 1)));
            chk_state("R8 wake returns to S0", S0);
        end
        chk("R5 mode kept through sleep", {7'b0, sci_en}, 8'd1);
    endtask

    task automatic t_ignored();
        wr_reg(2'd1, 4'b1000);
        chk_state("R7 code 0 ignored", S0);
        wr_reg(2'd1, 4'b1110);
        chk_state("R7 code 6 ignored", S0);
        wr_reg(2'd1, 4'b1111);
        chk_state("R7 code 7 ignored", S0);
        wr_reg(2'd1, 4'b0010);
        chk_state("R7 no trigger ignored", S0);
        repeat (3) @(negedge clk);
        chk_state("R7 trigger not stored", S0);
    endtask

    task automatic t_soft_off();
        wr_reg(2'd1, 4'b1101);
        chk_state("R6 code 5 to S5", S5);
        @(negedge clk);
        chk("R4 mode cleared in S5", {7'b0, sci_en}, 8'd0);
        boot_to_s0_acpi();
        chk_state("R3 reboot S0", S0);
    endtask

    task automatic t_override();
        pulse(pwrbtn_ovr);
        chk_state("R9 override from S0", S5);
        boot_to_s0_acpi();
        wr_reg(2'd1, 4'b1011);
        chk_state("R5 enter S3", S3);
        @(negedge clk); pwrbtn_ovr = 1'b1; wake_evt = 4'b1000;
        @(negedge clk); pwrbtn_ovr = 1'b0; wake_evt = '0;
        chk_state("R9 override beats wake", S5);
        boot_to_s0_acpi();
        @(negedge clk); pwrbtn_ovr = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 4'b1001;
        @(negedge clk); pwrbtn_ovr = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        chk_state("R9 override beats sleep write", S5);
    endtask

    task automatic t_fail();
        boot_to_s0_acpi();
        pulse(pwr_fail);
        chk_state("R10 fail from S0", G3);
        @(negedge clk);
        chk("R4 mode cleared in G3", {7'b0, sci_en}, 8'd0);
        @(negedge clk); pwr_fail = 1'b1; pwr_good = 1'b1;
        @(negedge clk); pwr_fail = 1'b0; pwr_good = 1'b0;
        chk_state("R10 fail beats power good", G3);
        pulse(pwr_good);
        boot_to_s0_acpi();
        wr_reg(2'd1, 4'b1010);
        @(negedge clk); pwr_fail = 1'b1; wake_evt = 4'b0010;
        @(negedge clk); pwr_fail = 1'b0; wake_evt = '0;
        chk_state("R10 fail beats wake in S2", G3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_power_up();
        t_mode();
        for (int d = 1; d <= 4; d++) t_sleep(d);
        t_ignored();
        t_soft_off();
        t_override();
        t_fail();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule